// File: doc/BRIEF.md
# Masked Time Alarm Comparator

This block watches the live calendar time and raises a sticky alarm flag when the time reaches a programmed alarm setting. Five alarm fields are compared: second, minute, hour, day of month and weekday. Each field has its own active-low enable bit, so software can build an alarm such as "every day at 07:30" by turning off the day and weekday fields. The alarm values are BCD, in the same encoding as the time counters that feed the block.

The time counters pulse a one-cycle strobe whenever they change. One cycle after that strobe the registered comparison result is evaluated. The flag sets only when the time moves into a matching state. While a match simply persists, for example when only the minute field is enabled and the seconds keep running, the flag does not set again after the host clears it. The hour is decoded to a time of day under the selected 12- or 24-hour mode before it is compared. An interrupt request follows the flag when the interrupt enable is high.

Top module: `masked_alarm_cmp`

## Requirements
- R1: While reset is high and on the first cycle after it, `alarm_flag` and `alarm_irq` are 0.
- R2: Each alarm input has an exclude bit at its top bit: `alm_sec[7]`, `alm_min[7]`, `alm_hour[6]`, `alm_day[6]` and `alm_wday[3]`. A value of 0 makes the field take part in the comparison. A value of 1 removes the field, and its value then has no effect.
- R3: The time matches when every included field equals the live time. The bits compared are second `[6:0]`, minute `[6:0]`, day `[5:0]` and weekday `[2:0]`, plus the decoded hour of R9.
- R4: When all five fields are excluded, the flag never sets.
- R5: The comparison is captured on the clock edge that samples `tick` high and is evaluated on the following edge. The flag is visible after that second edge. A change of the time inputs without `tick` has no effect.
- R6: Once set, `alarm_flag` stays at 1 until an edge samples `flag_clr` high. That edge clears it.
- R7: An evaluation sets the flag only if the previous evaluation was not a match. A match that persists across ticks does not set the flag again after a clear.
- R8: If a set and `flag_clr` fall on the same edge, the set wins and the flag is 1.
- R9: The hour decodes by mode. With `hour12`=0, bits `[5:0]` hold BCD 00 to 23. With `hour12`=1, bit 5 is PM and bits `[4:0]` hold BCD 01 to 12, where 12 AM is midnight. Alarm and live hours compare as time of day, so 7 PM (0x27) does not match 7 AM (0x07).
- R10: An hour code that is not valid for the current mode never matches, even when the live hour has the same code. For example, 0x13 matches in 24-hour mode but not in 12-hour mode.
- R11: `alarm_irq` is 1 exactly when `alarm_flag` is 1 and `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe: the time inputs have just changed |
| now_sec | input | 7 | Live seconds, BCD |
| now_min | input | 7 | Live minutes, BCD |
| now_hour | input | 6 | Live hour, BCD, encoded per `hour12` |
| now_day | input | 6 | Live day of month, BCD |
| now_wday | input | 3 | Live weekday 0..6 |
| alm_sec | input | 8 | Bit 7 exclude, [6:0] alarm seconds |
| alm_min | input | 8 | Bit 7 exclude, [6:0] alarm minutes |
| alm_hour | input | 7 | Bit 6 exclude, [5:0] alarm hour |
| alm_day | input | 7 | Bit 6 exclude, [5:0] alarm day |
| alm_wday | input | 4 | Bit 3 exclude, [2:0] alarm weekday |
| hour12 | input | 1 | 1 selects the 12-hour encoding with PM bit |
| irq_en | input | 1 | Alarm interrupt enable |
| flag_clr | input | 1 | Clears the alarm flag |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Interrupt request |

## Verification
The bench steps the time through sequences that approach, hit, stay on and leave an alarm setting. These cases separate an edge-qualified flag from a level one, and a match caught on a strobe from a change without one. Alarms with one field, several fields and no fields tell the active-low enable apart from a mismatch. Pairs of hour codes that are equal in raw bits but differ in time of day (AM against PM, a code invalid in 12-hour mode) show that the mode decoding is applied. A clear placed on the set edge shows which of the two wins.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;

    localparam int SEC_W   = 7;
    localparam int MIN_W   = 7;
    localparam int HOUR_W  = 6;
    localparam int DAY_W   = 6;
    localparam int WDAY_W  = 3;
    localparam int HOD_W   = 5;
    localparam int NPLAIN  = 4;
    localparam int NFIELDS = NPLAIN + 1;
    localparam int PLAIN_BITS = SEC_W + MIN_W + DAY_W + WDAY_W;

    typedef struct packed {
        logic incl;
        logic hit;
    } field_res_t;

    typedef struct packed {
        logic             ok;
        logic [HOD_W-1:0] hod;
    } hour_dec_t;

    // widths of the directly compared fields: sec, min, day, weekday
    function automatic int plain_w(input int i);
        case (i)
            0:       return SEC_W;
            1:       return MIN_W;
            2:       return DAY_W;
            default: return WDAY_W;
        endcase
    endfunction

    function automatic int plain_off(input int i);
        int acc;
        acc = 0;
        for (int k = 0; k < i; k++) acc += plain_w(k);
        return acc;
    endfunction

    // hour code -> hour of day 0..23 with validity for the given mode
    function automatic hour_dec_t decode_hour(input logic [HOUR_W-1:0] code,
                                              input logic mode12);
        hour_dec_t  d;
        logic [5:0] h;
        logic [5:0] base;
        if (mode12) begin
            h    = (code[4] ? 6'd10 : 6'd0) + {2'b00, code[3:0]};
            d.ok = (code[3:0] <= 4'd9) && (h >= 6'd1) && (h <= 6'd12);
            base = (h == 6'd12) ? 6'd0 : h;
            h    = base + (code[5] ? 6'd12 : 6'd0);
        end else begin
            h    = ({4'b0000, code[5:4]} * 6'd10) + {2'b00, code[3:0]};
            d.ok = (code[3:0] <= 4'd9) && (h <= 6'd23);
        end
        d.hod = h[HOD_W-1:0];
        return d;
    endfunction

endpackage

// File: rtl/alarm_field_match.sv
module alarm_field_match
    import alarm_cmp_pkg::*;
#(
    parameter int W = 7
) (
    input  logic         excl,
    input  logic [W-1:0] alarm_val,
    input  logic [W-1:0] live_val,
    input  logic         ok,
    output field_res_t   res
);
    always_comb begin
        res.incl = ~excl;
        res.hit  = ok && (alarm_val == live_val);
    end
endmodule

// File: rtl/alarm_flag_ctl.sv
module alarm_flag_ctl (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic match,
    input  logic clr,
    output logic flag
);
    logic eval_q;   // evaluation slot, one cycle after the strobe
    logic match_q;  // comparison captured at the strobe
    logic seen_q;   // result of the previous evaluation

    always_ff @(posedge clk) begin
        if (rst) begin
            eval_q  <= 1'b0;
            match_q <= 1'b0;
            seen_q  <= 1'b0;
            flag    <= 1'b0;
        end else begin
            eval_q <= tick;
            if (tick)   match_q <= match;
            if (eval_q) seen_q  <= match_q;
            if (eval_q && match_q && !seen_q) flag <= 1'b1;
            else if (clr)                     flag <= 1'b0;
        end
    end
endmodule

// File: rtl/masked_alarm_cmp.sv
module masked_alarm_cmp
    import alarm_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [SEC_W-1:0]  now_sec,
    input  logic [MIN_W-1:0]  now_min,
    input  logic [HOUR_W-1:0] now_hour,
    input  logic [DAY_W-1:0]  now_day,
    input  logic [WDAY_W-1:0] now_wday,
    input  logic [SEC_W:0]    alm_sec,
    input  logic [MIN_W:0]    alm_min,
    input  logic [HOUR_W:0]   alm_hour,
    input  logic [DAY_W:0]    alm_day,
    input  logic [WDAY_W:0]   alm_wday,
    input  logic              hour12,
    input  logic              irq_en,
    input  logic              flag_clr,
    output logic              alarm_flag,
    output logic              alarm_irq
);
    logic [PLAIN_BITS-1:0] alm_flat;
    logic [PLAIN_BITS-1:0] live_flat;
    logic [NPLAIN-1:0]     excl_flat;
    field_res_t            res [NFIELDS];
    hour_dec_t             hour_a;
    hour_dec_t             hour_l;
    logic                  any_incl;
    logic                  all_hit;
    logic                  match;

    assign alm_flat  = {alm_wday[WDAY_W-1:0], alm_day[DAY_W-1:0],
                        alm_min[MIN_W-1:0], alm_sec[SEC_W-1:0]};
    assign live_flat = {now_wday, now_day, now_min, now_sec};
    assign excl_flat = {alm_wday[WDAY_W], alm_day[DAY_W],
                        alm_min[MIN_W], alm_sec[SEC_W]};

    generate
        for (genvar i = 0; i < NPLAIN; i++) begin : g_plain
            localparam int FW = plain_w(i);
            localparam int FO = plain_off(i);
            alarm_field_match #(.W(FW)) u_fm (
                .excl      (excl_flat[i]),
                .alarm_val (alm_flat[FO+FW-1:FO]),
                .live_val  (live_flat[FO+FW-1:FO]),
                .ok        (1'b1),
                .res       (res[i])
            );
        end
    endgenerate

    assign hour_a = decode_hour(alm_hour[HOUR_W-1:0], hour12);
    assign hour_l = decode_hour(now_hour, hour12);

    alarm_field_match #(.W(HOD_W)) u_hour (
        .excl      (alm_hour[HOUR_W]),
        .alarm_val (hour_a.hod),
        .live_val  (hour_l.hod),
        .ok        (hour_a.ok && hour_l.ok),
        .res       (res[NPLAIN])
    );

    always_comb begin
        any_incl = 1'b0;
        all_hit  = 1'b1;
        for (int k = 0; k < NFIELDS; k++) begin
            any_incl = any_incl | res[k].incl;
            all_hit  = all_hit & (res[k].hit | ~res[k].incl);
        end
        match = any_incl & all_hit;
    end

    alarm_flag_ctl u_flag (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .match (match),
        .clr   (flag_clr),
        .flag  (alarm_flag)
    );

    assign alarm_irq = alarm_flag & irq_en;
endmodule

// File: rtl/alarm_cmp_checker.sv
module alarm_cmp_checker (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic irq_en,
    input logic flag_clr,
    input logic alarm_flag,
    input logic alarm_irq,
    input logic all_off
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> !alarm_flag); // R1

    AST_SET_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_flag) |-> $past(tick, 2)); // R5

    AST_NO_SET_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_flag) |-> !$past(all_off, 2)); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        alarm_flag && !flag_clr |=> alarm_flag); // R6

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        flag_clr && !$past(tick) |=> !alarm_flag); // R6

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !alarm_irq); // R11

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> alarm_flag); // R11
endmodule

bind masked_alarm_cmp alarm_cmp_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .irq_en     (irq_en),
    .flag_clr   (flag_clr),
    .alarm_flag (alarm_flag),
    .alarm_irq  (alarm_irq),
    .all_off    (alm_sec[7] && alm_min[7] && alm_hour[6] && alm_day[6] && alm_wday[3])
);

// File: tb/masked_alarm_cmp_bench.sv
module masked_alarm_cmp_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       tick;
    logic [6:0] now_sec, now_min;
    logic [5:0] now_hour, now_day;
    logic [2:0] now_wday;
    logic [7:0] alm_sec, alm_min;
    logic [6:0] alm_hour, alm_day;
    logic [3:0] alm_wday;
    logic       hour12, irq_en, flag_clr;
    logic       alarm_flag, alarm_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    masked_alarm_cmp u_masked_alarm_cmp (
        .clk(clk), .rst(rst), .tick(tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_day(now_day), .now_wday(now_wday),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
        .alm_day(alm_day), .alm_wday(alm_wday),
        .hour12(hour12), .irq_en(irq_en), .flag_clr(flag_clr),
        .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic disable_all();
        alm_sec = 8'h80; alm_min = 8'h80; alm_hour = 7'h40;
        alm_day = 7'h40; alm_wday = 4'h8;
    endtask

    task automatic set_time(input logic [5:0] h, input logic [6:0] m, input logic [6:0] s,
                            input logic [5:0] d, input logic [2:0] w);
        now_hour = h; now_min = m; now_sec = s; now_day = d; now_wday = w;
    endtask

    // drive a strobe with new time; returns after the evaluation edge
    task automatic step(input logic [5:0] h, input logic [6:0] m, input logic [6:0] s,
                        input logic [5:0] d, input logic [2:0] w);
        @(negedge clk);
        set_time(h, m, s, d, w);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "flag in reset", alarm_flag, 1'b0);
        check("R1", "irq in reset", alarm_irq, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "flag after reset", alarm_flag, 1'b0);
    endtask

    task automatic t_all_disabled();
        disable_all();
        step(6'h00, 7'h00, 7'h00, 6'h01, 3'd0);
        step(6'h00, 7'h00, 7'h01, 6'h01, 3'd0);
        step(6'h12, 7'h34, 7'h56, 6'h21, 3'd4);
        check("R4", "all fields excluded", alarm_flag, 1'b0);
    endtask

    task automatic t_minute_only();
        disable_all();
        alm_min = 8'h30;
        step(6'h10, 7'h29, 7'h59, 6'h05, 3'd2);
        check("R2", "minute 29 vs 30", alarm_flag, 1'b0);
        step(6'h10, 7'h30, 7'h00, 6'h05, 3'd2);
        check("R3", "minute hit, others excluded", alarm_flag, 1'b1);
        check("R11", "irq with enable", alarm_irq, 1'b1);
        step(6'h10, 7'h30, 7'h01, 6'h05, 3'd2);
        check("R6", "flag held", alarm_flag, 1'b1);
        @(negedge clk);
        irq_en = 1'b0;
        @(negedge clk);
        check("R11", "irq masked", alarm_irq, 1'b0);
        check("R11", "flag kept while masked", alarm_flag, 1'b1);
        irq_en = 1'b1;
        clear_flag();
        check("R6", "flag cleared", alarm_flag, 1'b0);
        step(6'h10, 7'h30, 7'h02, 6'h05, 3'd2);
        check("R7", "persisting match no reset", alarm_flag, 1'b0);
        step(6'h10, 7'h31, 7'h00, 6'h05, 3'd2);
        check("R7", "leaving match", alarm_flag, 1'b0);
        step(6'h10, 7'h30, 7'h00, 6'h05, 3'd2);
        check("R7", "re-entering match", alarm_flag, 1'b1);
        clear_flag();
    endtask

    task automatic t_no_tick();
        disable_all();
        alm_min = 8'h30;
        step(6'h10, 7'h31, 7'h00, 6'h05, 3'd2);
        @(negedge clk);
        now_min = 7'h30;
        repeat (3) @(negedge clk);
        check("R5", "change without tick", alarm_flag, 1'b0);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check("R5", "one edge after strobe", alarm_flag, 1'b0);
        @(negedge clk);
        check("R5", "two edges after strobe", alarm_flag, 1'b1);
        clear_flag();
    endtask

    task automatic t_multi_field();
        disable_all();
        alm_sec = 8'h45; alm_min = 8'h12; alm_hour = 7'h08;
        step(6'h08, 7'h12, 7'h44, 6'h09, 3'd1);
        check("R3", "second differs", alarm_flag, 1'b0);
        step(6'h08, 7'h12, 7'h45, 6'h09, 3'd1);
        check("R3", "sec+min+hour hit", alarm_flag, 1'b1);
        clear_flag();
        step(6'h09, 7'h12, 7'h45, 6'h09, 3'd1);
        check("R3", "hour differs", alarm_flag, 1'b0);
        alm_day = 7'h15; alm_wday = 4'h3;
        step(6'h08, 7'h12, 7'h45, 6'h15, 3'd2);
        check("R3", "weekday differs", alarm_flag, 1'b0);
        step(6'h08, 7'h12, 7'h45, 6'h14, 3'd3);
        check("R3", "day differs", alarm_flag, 1'b0);
        step(6'h08, 7'h12, 7'h45, 6'h15, 3'd3);
        check("R3", "all five hit", alarm_flag, 1'b1);
        clear_flag();
    endtask

    task automatic t_ampm();
        disable_all();
        hour12 = 1'b1;
        alm_hour = 7'h07;
        step(6'h27, 7'h00, 7'h00, 6'h01, 3'd0);
        check("R9", "7 PM vs 7 AM", alarm_flag, 1'b0);
        step(6'h07, 7'h00, 7'h00, 6'h01, 3'd0);
        check("R9", "7 AM hit", alarm_flag, 1'b1);
        clear_flag();
        alm_hour = 7'h12;
        step(6'h32, 7'h00, 7'h00, 6'h01, 3'd0);
        check("R9", "12 PM vs 12 AM", alarm_flag, 1'b0);
        step(6'h12, 7'h00, 7'h00, 6'h01, 3'd0);
        check("R9", "12 AM hit", alarm_flag, 1'b1);
        clear_flag();
    endtask

    task automatic t_invalid_hour();
        disable_all();
        hour12 = 1'b1;
        alm_hour = 7'h13;
        step(6'h13, 7'h00, 7'h00, 6'h01, 3'd0);
        check("R10", "code 13 in 12h mode", alarm_flag, 1'b0);
        hour12 = 1'b0;
        step(6'h13, 7'h00, 7'h01, 6'h01, 3'd0);
        check("R10", "code 13 in 24h mode", alarm_flag, 1'b1);
        clear_flag();
    endtask

    task automatic t_set_beats_clear();
        disable_all();
        alm_hour = 7'h05;
        step(6'h04, 7'h00, 7'h00, 6'h01, 3'd0);
        check("R8", "before set", alarm_flag, 1'b0);
        @(negedge clk);
        set_time(6'h05, 7'h00, 7'h00, 6'h01, 3'd0);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R8", "set wins over clear", alarm_flag, 1'b1);
        clear_flag();
        check("R6", "later clear", alarm_flag, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tick = 1'b0; flag_clr = 1'b0; hour12 = 1'b0; irq_en = 1'b1;
        disable_all();
        set_time(6'h00, 7'h00, 7'h00, 6'h01, 3'd0);
        repeat (3) @(negedge clk);
        t_reset();
        t_all_disabled();
        t_minute_only();
        t_no_tick();
        t_multi_field();
        t_ampm();
        t_invalid_hour();
        t_set_beats_clear();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule